// File: doc/BRIEF.md
# I2C Write-Only Target Receiver

This block is a 7-bit-address I2C target that only accepts write transfers. It samples the bus lines in the system clock domain through a two-flop synchronizer and finds SCL edges, START and STOP from the synchronized values. It then shifts in each byte MSB first. After eight bits it decides whether to pull SDA low on the ninth clock. SDA is an open-drain output: `sda_oe_o` high means the line is pulled low.

A matching address byte with a write direction bit is handled like a data byte. It is stored in the single holding register and flagged to the host. The host reads the holding register with a one-cycle strobe, which frees the register. The host also clears the per-byte interrupt flag and the sticky overrun flag.

A byte that arrives while the holding register is still unread is dropped and left unacknowledged, and the overrun flag is set. While the overrun flag is set, every later byte is also dropped and left unacknowledged.

Top module: `i2c_wr_target`

## Requirements
- R1: After a START, an address byte whose upper seven bits equal `own_addr_i` and whose last bit is 0 is acknowledged on the ninth clock. `dir_o` is cleared, and the whole byte, with the direction bit in bit 0, is stored in the holding register.
- R2: An address byte that does not match, or that matches with direction bit 1, is never acknowledged. SDA stays released and the buffer, `buf_full_o`, `ovf_o` and `irq_o` stay unchanged until the next START. A matching address also copies its direction bit to `dir_o`.
- R3: Data bytes after an acknowledged address are received MSB first and stored in the holding register. `buf_full_o` is already high during the ninth (acknowledge) clock of an accepted byte. SDA is driven low only while SCL is low or during the ninth clock.
- R4: A one-cycle `rd_i` pulse clears `buf_full_o`. `rd_data_o` always shows the holding register.
- R5: A byte that completes while `buf_full_o` is set, with no coincident read, gets no acknowledge and sets `ovf_o`. The holding register keeps the earlier byte.
- R6: While `ovf_o` is set, a completed byte gets no acknowledge and is not stored, even if `buf_full_o` is clear.
- R7: `irq_o` is set by every completed byte of an addressed transfer, the address byte included, whether the byte is accepted or rejected. It stays set until an `irq_clr_i` pulse; a set in the same cycle wins.
- R8: `ovf_o` stays set until an `ovf_clr_i` pulse; a set in the same cycle wins.
- R9: A STOP or repeated START before the eighth bit of a byte drops that byte, with no store, no flag change and no acknowledge. A repeated START restarts address reception.
- R10: A read strobe in the same cycle as the eighth-bit sample frees the register for the arriving byte. That byte is acknowledged and stored, `buf_full_o` stays high, and the read returns the earlier byte.
- R11: After reset `sda_oe_o`, `buf_full_o`, `ovf_o`, `irq_o`, `dir_o` are 0 and `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line (wired level) |
| sda_oe_o | output | 1 | High pulls SDA low |
| own_addr_i | input | 7 | Own target address |
| rd_i | input | 1 | Host read strobe for the holding register |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| ovf_clr_i | input | 1 | Clears the overrun flag |
| rd_data_o | output | 8 | Holding register |
| buf_full_o | output | 1 | Holding register holds an unread byte |
| ovf_o | output | 1 | Sticky overrun flag |
| irq_o | output | 1 | Per-byte interrupt flag |
| dir_o | output | 1 | Direction bit of the last matching address |

## Verification
A host read and the arrival of a new byte's eighth bit can fall in the same system clock cycle. The bench provokes this by placing the `rd_i` pulse exactly two clocks after it raises SCL for the eighth bit, which matches the synchronizer plus edge-detect latency. The bench judges the outcome three ways. The read must return the older byte, the new byte must be acknowledged, and the holding register must end up with the new byte while `buf_full_o` stays high. The same bench also runs the plain overrun path, with no read, next to it for contrast.

// File: rtl/i2c_wr_target_pkg.sv
package i2c_wr_target_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CNT_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_ACK_WAIT,
    ST_ACK_LO,
    ST_ACK_HI,
    ST_IGNORE
  } rx_state_e;
endpackage

// File: rtl/i2c_wr_target_cond.sv
module i2c_wr_target_cond #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned NSIG = 2;

  logic [NSIG-1:0] raw;
  logic [NSIG-1:0] synced;
  logic [NSIG-1:0] prev_q;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;  // idle bus is high
      else         chain_q <= {chain_q[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= synced;
  end

  assign scl_s_o    = synced[1];
  assign sda_s_o    = synced[0];
  assign scl_rise_o = synced[1] & ~prev_q[1];
  assign scl_fall_o = ~synced[1] & prev_q[1];
  assign start_o    = synced[1] & prev_q[1] & prev_q[0] & ~synced[0];
  assign stop_o     = synced[1] & prev_q[1] & ~prev_q[0] & synced[0];
endmodule

// File: rtl/i2c_wr_target_fsm.sv
module i2c_wr_target_fsm
  import i2c_wr_target_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              accept_i,
  output logic              byte_evt_o,
  output logic [DATA_W-1:0] byte_data_o,
  output logic              sda_oe_o,
  output logic              dir_o
);
  rx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q;
  logic              ack_pend_q;
  logic              sda_oe_q;
  logic              dir_q;
  logic              last_bit;
  logic              addr_hit;

  assign last_bit    = scl_rise_i && (cnt_q == CNT_W'(DATA_W-1));
  assign byte_data_o = {sh_q[DATA_W-2:0], sda_s_i};
  assign addr_hit    = (sh_q[ADDR_W-1:0] == own_addr_i);
  assign byte_evt_o  = last_bit && !start_i && !stop_i &&
                       ((state_q == ST_DATA) ||
                        (state_q == ST_ADDR && addr_hit && !sda_s_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      ack_pend_q <= 1'b0;
      sda_oe_q   <= 1'b0;
      dir_q      <= 1'b0;
    end else if (start_i) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop_i) begin
      state_q  <= ST_IDLE;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_DATA: if (scl_rise_i) begin
          sh_q  <= byte_data_o;
          cnt_q <= cnt_q + 1'b1;
          if (last_bit) begin
            if (state_q == ST_ADDR && !addr_hit) begin
              state_q <= ST_IGNORE;
            end else begin
              if (state_q == ST_ADDR) dir_q <= sda_s_i;
              if (state_q == ST_ADDR && sda_s_i) begin
                state_q <= ST_IGNORE;
              end else begin
                state_q    <= ST_ACK_WAIT;
                ack_pend_q <= accept_i;
              end
            end
          end
        end
        ST_ACK_WAIT: if (scl_fall_i) begin
          sda_oe_q <= ack_pend_q;
          state_q  <= ST_ACK_LO;
        end
        ST_ACK_LO: if (scl_rise_i) state_q <= ST_ACK_HI;
        ST_ACK_HI: if (scl_fall_i) begin
          sda_oe_q <= 1'b0;
          cnt_q    <= '0;
          state_q  <= ST_DATA;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;
  assign dir_o    = dir_q;

  AST_NACK_ON_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_evt_o && !accept_i |=> !ack_pend_q); // R5
  AST_OE_WHILE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_s_i); // R3
  AST_IGNORE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IGNORE |-> !sda_oe_q); // R2
endmodule

// File: rtl/i2c_wr_target_regs.sv
module i2c_wr_target_regs
  import i2c_wr_target_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_evt_i,
  input  logic [DATA_W-1:0] byte_data_i,
  input  logic              rd_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic              accept_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] buf_q;
  logic              bf_q;
  logic              ovf_q;
  logic              irq_q;

  // a read in the same cycle frees the holding register
  assign accept_o = (!bf_q || rd_i) && !ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      bf_q  <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (byte_evt_i && accept_o) begin
        buf_q <= byte_data_i;
        bf_q  <= 1'b1;
      end else if (rd_i) begin
        bf_q <= 1'b0;
      end
      if (byte_evt_i && !accept_o) ovf_q <= 1'b1;
      else if (ovf_clr_i)          ovf_q <= 1'b0;
      if (byte_evt_i)              irq_q <= 1'b1;
      else if (irq_clr_i)          irq_q <= 1'b0;
    end
  end

  assign rd_data_o  = buf_q;
  assign buf_full_o = bf_q;
  assign ovf_o      = ovf_q;
  assign irq_o      = irq_q;

  AST_OVF_KEEPS_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_evt_i && !accept_o |=> $stable(buf_q)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !ovf_clr_i |=> ovf_q); // R8
  AST_IRQ_PER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_evt_i |=> irq_q); // R7
  AST_READ_CLEARS_BF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !byte_evt_i |=> !bf_q); // R4
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
  import i2c_wr_target_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              rd_i,
  input  logic              irq_clr_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              buf_full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              dir_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic accept, byte_evt;
  logic [DATA_W-1:0] byte_data;

  i2c_wr_target_cond #(.STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_s_o(scl_s), .sda_s_o(sda_s), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  i2c_wr_target_fsm u_fsm (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start),
    .stop_i(stop), .own_addr_i, .accept_i(accept), .byte_evt_o(byte_evt),
    .byte_data_o(byte_data), .sda_oe_o, .dir_o
  );

  i2c_wr_target_regs u_regs (
    .clk_i, .rst_ni, .byte_evt_i(byte_evt), .byte_data_i(byte_data),
    .rd_i, .irq_clr_i, .ovf_clr_i, .accept_o(accept), .rd_data_o,
    .buf_full_o, .ovf_o, .irq_o
  );
endmodule

// File: tb/i2c_wr_target_bench.sv
module i2c_wr_target_bench;
  localparam int H = 6;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic rd = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic sda_oe, bf, ovf, irq, dir;
  logic [7:0] rd_data;
  logic sda_line;

  int checks = 0;
  int failures = 0;
  logic [7:0] m_buf = '0;
  logic m_bf = 0, m_ovf = 0, m_irq = 0;
  logic coin_seen_ok;
  logic [7:0] coin_data;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_wr_target u_i2c_wr_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .own_addr_i(OWN), .rd_i(rd), .irq_clr_i(irq_clr),
    .ovf_clr_i(ovf_clr), .rd_data_o(rd_data), .buf_full_o(bf), .ovf_o(ovf),
    .irq_o(irq), .dir_o(dir)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_accept(input logic coin);
    return (!m_bf || coin) && !m_ovf;
  endfunction

  task automatic do_start();
    sda_m = 1; scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(2);
  endtask

  task automatic do_rstart();
    sda_m = 1; w(H); scl_m = 1; w(H); sda_m = 0; w(H); scl_m = 0; w(2);
  endtask

  task automatic do_stop();
    sda_m = 0; w(H); scl_m = 1; w(H); sda_m = 1; w(H);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = d[i]; w(H); scl_m = 1; w(H); scl_m = 0; w(2);
    end
  endtask

  // full byte; coin puts a read strobe on the eighth-bit sample cycle
  task automatic send_byte(input logic [7:0] d, input bit coin,
                           output bit acked, output logic bf_at_ack);
    send_bits(d, 7);
    sda_m = d[0]; w(H); scl_m = 1;
    if (coin) begin
      w(2); rd = 1; coin_data = rd_data; w(1); rd = 0; w(H - 3);
    end else w(H);
    scl_m = 0; w(2);
    sda_m = 1; w(H); scl_m = 1; w(H / 2);
    acked = !sda_line; bf_at_ack = bf;
    w(H - H / 2); scl_m = 0; w(2);
  endtask

  task automatic byte_and_check(input logic [7:0] d, input bit addressed,
                                input bit coin, input string req);
    bit ack; logic bfa; logic acc;
    logic [7:0] old = m_buf;
    acc = addressed && exp_accept(coin);
    send_byte(d, coin, ack, bfa);
    if (addressed) begin
      if (acc) begin m_buf = d; m_bf = 1; end
      else begin m_ovf = 1; if (coin) m_bf = 0; end
      m_irq = 1;
    end
    chk(ack == acc, req, ack, acc);
    chk(bfa == m_bf, {req, " bf@ack"}, bfa, m_bf);
    chk(rd_data == m_buf, {req, " buf"}, rd_data, m_buf);
    chk(ovf == m_ovf, {req, " ovf"}, ovf, m_ovf);
    chk(irq == m_irq, {req, " irq"}, irq, m_irq);
    if (coin) chk(coin_data == old, "R10 read returns old", coin_data, old);
  endtask

  task automatic host_read();
    chk(rd_data == m_buf, "R4 read data", rd_data, m_buf);
    rd = 1; w(1); rd = 0; w(1);
    m_bf = 0;
    chk(bf == 0, "R4 bf cleared", bf, 0);
  endtask

  task automatic clr_irq();
    irq_clr = 1; w(1); irq_clr = 0; w(1); m_irq = 0;
    chk(irq == 0, "R7 irq clear", irq, 0);
  endtask

  task automatic clr_ovf();
    ovf_clr = 1; w(1); ovf_clr = 0; w(1); m_ovf = 0;
    chk(ovf == 0, "R8 ovf clear", ovf, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    w(3); rst_n = 1; w(2);
    // R11 reset state
    chk(sda_oe == 0 && bf == 0 && ovf == 0 && irq == 0 && dir == 0,
        "R11 reset flags", {sda_oe, bf, ovf, irq, dir}, 0);
    chk(rd_data == 0, "R11 reset data", rd_data, 0);

    // R1 address, R3 data, R5 overflow, R6 ovf suppression, R8 sticky
    do_start();
    byte_and_check({OWN, 1'b0}, 1, 0, "R1 addr ack");
    chk(dir == 0, "R1 dir", dir, 0);
    host_read();
    byte_and_check(8'hA5, 1, 0, "R3 data ack");
    byte_and_check(8'h3C, 1, 0, "R5 overflow nack");
    host_read();
    byte_and_check(8'h77, 1, 0, "R6 ovf blocks");
    chk(ovf == 1, "R8 ovf sticky", ovf, 1);
    clr_ovf();
    byte_and_check(8'h77, 1, 0, "R3 data after clr");
    // R10 coincident read with eighth bit
    byte_and_check(8'h11, 1, 1, "R10 coincident accept");
    chk(bf == 1, "R10 bf stays", bf, 1);
    do_stop();

    // R9 STOP aborts a byte
    host_read(); clr_irq();
    do_start();
    byte_and_check({OWN, 1'b0}, 1, 0, "R1 addr ack 2");
    host_read(); clr_irq();
    send_bits(8'hF0, 4); do_stop();
    chk(irq == 0 && bf == 0, "R9 stop abort", {irq, bf}, 0);
    chk(rd_data == m_buf, "R9 stop buf", rd_data, m_buf);

    // R9 repeated START aborts a byte and restarts address phase
    do_start();
    byte_and_check({OWN, 1'b0}, 1, 0, "R1 addr ack 3");
    host_read(); clr_irq();
    send_bits(8'h0F, 3); do_rstart();
    chk(irq == 0, "R9 rstart abort", irq, 0);
    byte_and_check({OWN, 1'b0}, 1, 0, "R9 rstart addr");
    host_read();
    do_stop();

    // R2 read direction on own address
    do_start();
    byte_and_check({OWN, 1'b1}, 0, 0, "R2 read dir ignored");
    chk(dir == 1, "R2 dir copy", dir, 1);
    byte_and_check(8'h55, 0, 0, "R2 ignored data");
    do_stop();

    // random transfers
    for (int t = 0; t < 40; t++) begin
      bit match = ($urandom % 4) != 0;
      bit rw = ($urandom % 8) == 0;
      logic [6:0] a = match ? OWN : (OWN ^ 7'(1 + $urandom % 127));
      bit addressed = match && !rw;
      int nb = $urandom % 4;
      do_start();
      byte_and_check({a, rw}, addressed, 0, addressed ? "R1 rnd addr" : "R2 rnd addr");
      if (match) chk(dir == rw, "R2 rnd dir", dir, rw);
      for (int b = 0; b < nb; b++) begin
        byte_and_check(8'($urandom), addressed, 0,
                       !addressed ? "R2 rnd data" : (m_ovf ? "R6 rnd" :
                       (m_bf ? "R5 rnd" : "R3 rnd")));
        if ($urandom % 2 == 0) host_read();
        if ($urandom % 3 == 0) clr_irq();
        if ($urandom % 5 == 0) clr_ovf();
      end
      do_stop();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule